// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register accesses on a two-wire PHY management bus. The host raises a one-cycle start strobe together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then drives a complete serial frame on the management clock output and the bidirectional data line. It finishes with a one-cycle completion pulse. On reads it also presents the 16 bits it captured. The data line is modelled as three signals: an output level, an output enable, and the level sensed back from the pad.

Every frame opens with a long preamble of 40 ones. After that come the start pattern, the two-bit operation code, both addresses and the turnaround. Then the 16 data bits move, most significant first. Each access closes with one extra clock period during which the line is released. One bit occupies one bit slot. A slot has a low half, in which the data level is set up, and a high half, in which the level is held. A divider sets the length of each half as a whole number of system clocks.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and between frames, `mdc_o` is low, `mdio_oe_o` is low, `busy_o` and `done_o` are low, and `rd_data_o` is 0.
- R2: A frame starts with 40 bit slots that drive 1 on `mdio_o` with `mdio_oe_o` high.
- R3: After the preamble the slots carry 0, 1 (start), then 1, 0 for a read (`rd_nwr_i`=1) or 0, 1 for a write (`rd_nwr_i`=0).
- R4: The next ten slots carry `phy_addr_i` bit 4 down to bit 0, then `reg_addr_i` bit 4 down to bit 0.
- R5: In every slot `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low, and they stay constant while `mdc_o` is high.
- R6: On a read, `mdio_oe_o` falls at the start of slot 54 (the single turnaround slot) and stays low until the frame ends.
- R7: On a read, `mdio_i` is sampled on the system clock edge that ends each of slots 55 to 70, most significant bit first. The 16 samples appear on `rd_data_o` in the cycle `done_o` is high. Slot 71 is a trailing released slot, so a read lasts 72 slots.
- R8: On a write, slots 54 and 55 drive 1 then 0. Slots 56 to 71 then drive `wr_data_i` bit 15 down to bit 0.
- R9: On a write, `mdio_oe_o` falls at the start of slot 72, a trailing released slot, so a write lasts 73 slots.
- R10: `busy_o` rises on the edge that accepts a start. `done_o` is high for exactly one cycle, on the edge that ends the last slot, and in that cycle `busy_o` is already low. The accepting edge through the done edge span 2·HALF_DIV·slots + 1 edges.
- R11: A start strobe that arrives while `busy_o` is high has no effect on the frame in progress.
- R12: `rd_data_o` changes only when a read completes. A write leaves it unchanged.
- R13: Each low half and each high half of `mdc_o` lasts HALF_DIV system clocks. The default of 50 gives 2.5 MHz from a 250 MHz clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| rd_nwr_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wr_data_i | input | 16 | Value to write |
| rd_data_o | output | 16 | Last completed read value |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output level |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line sensed level |

## Verification
Reads and writes go to opposite corners of the address space: PHY 0x11 with register 0x0A, PHY 0x1F with register 0x00, and PHY 0x00 with register 0x1F. A wrong bit order in either address field therefore shows up as a wrong slot value. The read patterns (0xA5C3, 0x5A3C, 0x0000) and write values (0x8001, 0xFFFF) separate sampling order, sampling slot and lost edge bits. `mdio_i` toggles outside the data slots, so capture in the wrong slot is caught. A write carrying a conflicting start strobe sits between two reads, which shows whether restarts are blocked and whether read data is held. A back-to-back read then starts in the cycle right after a completion pulse.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  // start(2) + op(2) + phy(5) + reg(5) + turnaround(2) + data(16)
  localparam int unsigned BODY_W   = 4 + 2*ADDR_W + 2 + DATA_W;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } mdio_op_e;

  function automatic int unsigned slot_w(int unsigned pre_len);
    return $clog2(pre_len + BODY_W + 2);
  endfunction
endpackage

// File: rtl/mdc_timer.sv
module mdc_timer #(
  parameter int unsigned HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic half_end_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!run_i)                 cnt_d = '0;
    else if (cnt_q == CNT_LAST) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign half_end_o = run_i && (cnt_q == CNT_LAST);

  // R13: a half period never ends twice in a row unless it is one clock long
  p_half_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end_o && run_i && (HALF_DIV > 1)) |=> !half_end_o);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 40,
  localparam int unsigned SW     = slot_w(PRE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rd_nwr_i,
  input  logic          half_end_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          mdc_o,
  output logic          rd_op_o,
  output logic [SW-1:0] slot_o,
  output logic          slot_end_o
);
  localparam logic [SW-1:0] RD_LAST = SW'(PRE_LEN + BODY_W - 1);
  localparam logic [SW-1:0] WR_LAST = SW'(PRE_LEN + BODY_W);

  logic          busy_q, busy_d;
  logic          ph_q, ph_d;
  logic          done_q, done_d;
  mdio_op_e      op_q, op_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [SW-1:0] last_slot;
  logic          accept;

  assign accept    = start_i && !busy_q;
  assign last_slot = (op_q == OP_READ) ? RD_LAST : WR_LAST;

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    slot_d = slot_q;
    op_d   = op_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      ph_d   = 1'b0;
      slot_d = '0;
      op_d   = mdio_op_e'(rd_nwr_i);
    end else if (busy_q && half_end_i) begin
      if (!ph_q) begin
        ph_d = 1'b1;
      end else begin
        ph_d = 1'b0;
        if (slot_q == last_slot) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_WRITE;
      slot_q <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      done_q <= done_d;
      op_q   <= op_d;
      slot_q <= slot_d;
    end
  end

  assign accept_o   = accept;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign mdc_o      = ph_q;
  assign rd_op_o    = (op_q == OP_READ);
  assign slot_o     = slot_q;
  assign slot_end_o = busy_q && half_end_i && ph_q;

  // R1: clock rests low while idle
  p_mdc_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !ph_q);
  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10: busy already low when done shows
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R11: busy only rises after a start request
  p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i));
  // R11: a start while busy leaves slot and phase untouched
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !half_end_i) |=> (slot_q == $past(slot_q)) && (ph_q == $past(ph_q)));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 40,
  localparam int unsigned SW     = slot_w(PRE_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              rd_nwr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_op_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              mdc_i,
  input  logic [SW-1:0]     slot_i,
  input  logic              slot_end_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [SW-1:0] PRE_END  = SW'(PRE_LEN);
  localparam logic [SW-1:0] RD_REL   = SW'(PRE_LEN + 4 + 2*ADDR_W);
  localparam logic [SW-1:0] RD_FIRST = SW'(PRE_LEN + 4 + 2*ADDR_W + 1);
  localparam logic [SW-1:0] RD_LASTD = SW'(PRE_LEN + 4 + 2*ADDR_W + DATA_W);
  localparam logic [SW-1:0] RD_LAST  = SW'(PRE_LEN + BODY_W - 1);
  localparam logic [SW-1:0] WR_REL   = SW'(PRE_LEN + BODY_W);

  logic [BODY_W-1:0] tx_q, tx_d;
  logic              tx_en;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic              cap_en;
  logic [DATA_W-1:0] rd_q;
  logic              rd_en;
  logic              in_body, drive;

  assign in_body = (slot_i >= PRE_END);

  always_comb begin
    tx_en = accept_i || (slot_end_i && in_body);
    if (accept_i)
      tx_d = {2'b01, (rd_nwr_i ? 2'b10 : 2'b01), phy_i, reg_i, 2'b10, wdata_i};
    else
      tx_d = {tx_q[BODY_W-2:0], 1'b0};
  end

  assign cap_en = slot_end_i && rd_op_i && (slot_i >= RD_FIRST) && (slot_i <= RD_LASTD);
  assign cap_d  = {cap_q[DATA_W-2:0], mdio_i};
  assign rd_en  = slot_end_i && rd_op_i && (slot_i == RD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      cap_q <= '0;
      rd_q  <= '0;
    end else begin
      if (tx_en)  tx_q  <= tx_d;
      if (cap_en) cap_q <= cap_d;
      if (rd_en)  rd_q  <= cap_q;
    end
  end

  assign drive     = busy_i && (slot_i < (rd_op_i ? RD_REL : WR_REL));
  assign mdio_oe_o = drive;
  assign mdio_o    = drive && (in_body ? tx_q[BODY_W-1] : 1'b1);
  assign rd_data_o = rd_q;

  // R5: line held steady through the high half of the clock
  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_i && $past(mdc_i)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
  // R6: read frame keeps the line released from the turnaround on
  p_release_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_op_i && (slot_i >= RD_REL)) |-> !mdio_oe_o);
  // R12: read data only moves in the completion cycle
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> $stable(rd_q));
  // R1: never driving while idle
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV = 50,
  parameter int unsigned PRE_LEN  = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rd_nwr_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int unsigned SW = slot_w(PRE_LEN);

  logic          half_end, accept, busy, done, mdc, rd_op, slot_end;
  logic [SW-1:0] slot;

  mdc_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (busy),
    .half_end_o (half_end)
  );

  mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_nwr_i   (rd_nwr_i),
    .half_end_i (half_end),
    .accept_o   (accept),
    .busy_o     (busy),
    .done_o     (done),
    .mdc_o      (mdc),
    .rd_op_o    (rd_op),
    .slot_o     (slot),
    .slot_end_o (slot_end)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .rd_nwr_i   (rd_nwr_i),
    .phy_i      (phy_addr_i),
    .reg_i      (reg_addr_i),
    .wdata_i    (wr_data_i),
    .rd_op_i    (rd_op),
    .busy_i     (busy),
    .done_i     (done),
    .mdc_i      (mdc),
    .slot_i     (slot),
    .slot_end_i (slot_end),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rd_data_o  (rd_data_o)
  );

  assign busy_o = busy;
  assign done_o = done;
  assign mdc_o  = mdc;
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int HD  = 4;
  localparam int PRE = 40;
  localparam int SL  = 2 * HD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rd_nwr = 1'b0;
  logic [4:0]  phy = '0, rga = '0;
  logic [15:0] wd = '0;
  logic [15:0] rd_data;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(HD), .PRE_LEN(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_nwr_i(rd_nwr),
    .phy_addr_i(phy), .reg_addr_i(rga), .wr_data_i(wd), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  logic [15:0] pat = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          t = 0;
  bit          mbusy = 0, mdone = 0, mrd = 0;
  logic [4:0]  mphy = '0, mreg = '0;
  logic [15:0] mwd = '0, mcap = '0, mrdata = '0;

  function automatic int frame_slots(bit rd);
    return rd ? PRE + 32 : PRE + 33;
  endfunction

  function automatic bit exp_bit(int s);
    int k;
    if (s < PRE) return 1'b1;
    k = s - PRE;
    if (k == 0) return 1'b0;
    if (k == 1) return 1'b1;
    if (k == 2) return mrd;
    if (k == 3) return !mrd;
    if (k < 9)  return mphy[8 - k];
    if (k < 14) return mreg[13 - k];
    if (k == 14) return 1'b1;
    if (k == 15) return 1'b0;
    return mwd[31 - k];
  endfunction

  function automatic string tag_of(int s);
    if (s < PRE) return "R2";
    if (s < PRE + 4) return "R3";
    if (s < PRE + 14) return "R4";
    return "R8";
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mbusy = 0; mdone = 0; t = 0; mcap = '0; mrdata = '0;
    end else begin
      mdone = 0;
      if (mbusy) begin
        t++;
        if (t % SL == 0) begin
          int se;
          se = t / SL - 1;
          if (mrd && se >= PRE + 15 && se <= PRE + 30) mcap = {mcap[14:0], mdio_i};
          if (se == frame_slots(mrd) - 1) begin
            mbusy = 0; mdone = 1;
            if (mrd) mrdata = mcap;
          end
        end
      end else if (start) begin
        mbusy = 1; t = 0; mrd = rd_nwr; mphy = phy; mreg = rga; mwd = wd;
      end
    end
  end

  // PHY side: data slots carry the pattern, other slots a toggling junk level
  always @(negedge clk) begin
    int s;
    s = t / SL;
    if (mbusy && mrd && s >= PRE + 15 && s <= PRE + 30) mdio_i <= pat[15 - (s - PRE - 15)];
    else mdio_i <= cyc[1];
  end

  // ---------------- per-cycle comparison ----------------
  bit   prev_mdc = 0, prev_o = 0, prev_oe = 0;
  int   hi_len = 0, lo_len = 0, r5_bad = 0, r13_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int  s;
      bit  e_mdc, e_oe;
      s     = t / SL;
      e_mdc = mbusy && ((t % SL) >= HD);
      e_oe  = mbusy && (s < (mrd ? PRE + 14 : PRE + 32));
      chk(mdc == e_mdc, "R13", 32'(mdc), 32'(e_mdc));
      chk(busy == mbusy && done == mdone, "R10", {busy, done}, {mbusy, mdone});
      chk(mdio_oe == e_oe, mrd ? "R6" : (s >= PRE + 32 ? "R9" : "R2"), 32'(mdio_oe), 32'(e_oe));
      if (e_oe) chk(mdio_o == exp_bit(s), tag_of(s), 32'(mdio_o), 32'(exp_bit(s)));
      chk(rd_data == mrdata, "R7", 32'(rd_data), 32'(mrdata));
      if (mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe)) r5_bad++;
      if (mdc) hi_len++;
      else if (prev_mdc) begin if (hi_len != HD) r13_bad++; hi_len = 0; end
      if (busy && !mdc) lo_len++;
      else if (lo_len != 0) begin if (lo_len != HD) r13_bad++; lo_len = 0; end
      prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end
  end

  // ---------------- stimulus ----------------
  task automatic frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input logic [15:0] rpat, input bit spurious);
    int c0, c1, n;
    @(negedge clk);
    rd_nwr = rd; phy = p; rga = r; wd = d; pat = rpat; start = 1'b1;
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (spurious && n == 300) begin
        start = 1'b1; rd_nwr = !rd; phy = ~p; rga = ~r; wd = ~d;   // R11 stimulus
      end
      if (spurious && n == 303) start = 1'b0;
    end
    c1 = cyc;
    chk(c1 - c0 == frame_slots(rd) * SL + 1, rd ? "R10 read length" : "R10 write length",
        32'(c1 - c0), 32'(frame_slots(rd) * SL + 1));
    chk(!busy, "R10 busy low at done", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy && !done && rd_data == 16'h0, "R1 reset state",
        {mdc, mdio_oe, busy, done, rd_data}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy, "R1 idle after reset", {mdc, mdio_oe, busy}, 32'h0);

    frame(1'b1, 5'h11, 5'h0A, 16'h0, 16'hA5C3, 1'b0);
    chk(rd_data == 16'hA5C3, "R7 first read", 32'(rd_data), 32'hA5C3);

    frame(1'b0, 5'h1F, 5'h00, 16'h8001, 16'h0, 1'b1);
    chk(rd_data == 16'hA5C3, "R12 held over write", 32'(rd_data), 32'hA5C3);
    chk(!busy, "R11 spurious start did not restart", 32'(busy), 32'd0);

    frame(1'b1, 5'h00, 5'h1F, 16'h0, 16'h5A3C, 1'b0);
    chk(rd_data == 16'h5A3C, "R7 second read", 32'(rd_data), 32'h5A3C);

    frame(1'b0, 5'h0A, 5'h15, 16'hFFFF, 16'h0, 1'b0);
    chk(rd_data == 16'h5A3C, "R12 held over second write", 32'(rd_data), 32'h5A3C);

    frame(1'b1, 5'h15, 5'h0A, 16'h0, 16'h0000, 1'b0);
    chk(rd_data == 16'h0000, "R7 back-to-back zero read", 32'(rd_data), 32'h0);

    repeat (20) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy, "R1 idle after frames", {mdc, mdio_oe, busy}, 32'h0);
    chk(r5_bad == 0, "R5 line stable while clock high", 32'(r5_bad), 32'd0);
    chk(r13_bad == 0, "R13 half period length", 32'(r13_bad), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule